// File: doc/BRIEF.md
# Round-Robin Unit Selector for a Resource Group

This block decides which execution unit of a resource group serves the next request. Each unit is one bit of a one-hot mask, and the group is the set of all `UNITS` bits. Three registers hold the selector state:

- a ready set, which holds the units that are currently free;
- a rotation set, which holds the units still waiting for a turn in the current round;
- a deferred set, which holds the units that will sit out the next round.

A request returns a one-hot grant in the same cycle. The grant is the highest-numbered unit of the rotation set that is ready. Any candidate that is not ready is skipped over, and this skip is committed to the state.

The surrounding scheduler drives two per-unit vectors:

- `busy_vec` reports the units that have just become fully occupied. Such a unit is marked not ready and is taken out of the rotation.
- `free_vec` reports the units that have finished their work. Such a unit is marked ready again.

A unit taken out while it sits above the current candidate is deferred. When the rotation set runs dry, it is refilled with the whole group minus the deferred set, and the deferred set is then cleared. A single output tells whether any unit is free.

Top module: `rr_unit_select`

## Requirements
- R1: After reset, all units are ready, the rotation set holds every unit and the deferred set is empty. A first request is therefore granted the highest unit, bit `UNITS-1`.
- R2: `grant_onehot` is one-hot or zero, and it is non-zero only while `pick_req` is high. When a request arrives and at least one unit is ready, `grant_hit` is high and `grant_onehot` is non-zero in that same cycle.
- R3: The candidate is the highest set bit of the rotation set. When the candidate's ready bit is low, that bit is cleared from the rotation set and the next candidate is tried. When the set empties, it is refilled as in R4. The grant is the first candidate found that is ready.
- R4: The rotation set is never empty. A refill loads the whole group XOR the deferred set, and then clears the deferred set.
- R5: A bit high in `busy_vec` clears that unit's ready bit from the next cycle on, unless `free_vec` sets the same bit. It also clears the unit from the rotation set. When the unit's one-hot value is numerically greater than the current candidate, the unit is added to the deferred set, so the next refill leaves it out.
- R6: When several bits of `busy_vec` are high in one cycle, they are taken out one at a time, from the highest index down. Each removal sees the candidate left by the removal before it.
- R7: A bit high in `free_vec` makes that unit ready from the next cycle on, and it takes precedence over `busy_vec`. It does not put the unit back into the rotation set.
- R8: `any_free` is high exactly when the ready set is non-zero.
- R9: The skips of a granted request are committed before `busy_vec` is applied in the same cycle. A request that finds no ready unit leaves the rotation and deferred sets unchanged. Without a request or `busy_vec`, neither set changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pick_req | input | 1 | Request a unit this cycle |
| grant_onehot | output | UNITS | One-hot unit granted this cycle |
| grant_hit | output | 1 | A unit was granted this cycle |
| busy_vec | input | UNITS | Units that have just become fully occupied |
| free_vec | input | UNITS | Units that have just become free |
| any_free | output | 1 | At least one unit is ready |

## Verification
The grant, `grant_hit` and `any_free` are combinational from the inputs and the registered state, so each is due in the very cycle its request is made. The bench drives each stimulus on a falling edge and pushes the expected values, taken from a reference model of the rotation rules, into a queue. A monitor pops each entry a quarter period later, before the next rising edge. The effects of `busy_vec` and `free_vec` land on the rising edge, so they are seen one cycle later, in the grant and `any_free` of the next stimulus.

// File: rtl/rr_unit_select_pkg.sv
package rr_unit_select_pkg;
    localparam int unsigned RUS_UNITS_DEFAULT = 4;
    // Search stages per unit: the rest of the current round, one refill
    // without deferred units, and one full refill always reach a ready unit.
    localparam int unsigned RUS_SEARCH_ROUNDS = 3;
endpackage

// File: rtl/rr_pick_stage.sv
module rr_pick_stage #(
    parameter int unsigned UNITS = 4
) (
    input  logic [UNITS-1:0] ready_i,
    input  logic [UNITS-1:0] seq_i,
    input  logic [UNITS-1:0] defer_i,
    input  logic             hit_i,
    input  logic [UNITS-1:0] grant_i,
    output logic [UNITS-1:0] seq_o,
    output logic [UNITS-1:0] defer_o,
    output logic             hit_o,
    output logic [UNITS-1:0] grant_o
);
    localparam logic [UNITS-1:0] GROUP = {UNITS{1'b1}};

    function automatic logic [UNITS-1:0] top_bit(input logic [UNITS-1:0] m);
        logic [UNITS-1:0] r;
        r = '0;
        for (int i = 0; i < UNITS; i++) begin
            if (m[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

    logic [UNITS-1:0] cand;
    logic [UNITS-1:0] rest;

    always_comb begin
        cand    = top_bit(seq_i);
        rest    = seq_i & ~cand;
        seq_o   = seq_i;
        defer_o = defer_i;
        hit_o   = hit_i;
        grant_o = grant_i;
        if (!hit_i) begin
            if ((cand & ready_i) != '0) begin
                hit_o   = 1'b1;
                grant_o = cand;
            end else if (rest == '0) begin
                seq_o   = GROUP ^ defer_i;
                defer_o = '0;
            end else begin
                seq_o   = rest;
            end
        end
    end
endmodule

// File: rtl/rr_pick.sv
module rr_pick
    import rr_unit_select_pkg::*;
#(
    parameter int unsigned UNITS = 4
) (
    input  logic [UNITS-1:0] ready_i,
    input  logic [UNITS-1:0] seq_i,
    input  logic [UNITS-1:0] defer_i,
    output logic [UNITS-1:0] seq_o,
    output logic [UNITS-1:0] defer_o,
    output logic             hit_o,
    output logic [UNITS-1:0] grant_o
);
    localparam int unsigned STAGES = RUS_SEARCH_ROUNDS * UNITS;

    logic [UNITS-1:0] seq_c   [0:STAGES];
    logic [UNITS-1:0] defer_c [0:STAGES];
    logic [UNITS-1:0] grant_c [0:STAGES];
    logic             hit_c   [0:STAGES];

    assign seq_c[0]   = seq_i;
    assign defer_c[0] = defer_i;
    assign grant_c[0] = '0;
    assign hit_c[0]   = 1'b0;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        rr_pick_stage #(.UNITS(UNITS)) u_stage (
            .ready_i (ready_i),
            .seq_i   (seq_c[k]),
            .defer_i (defer_c[k]),
            .hit_i   (hit_c[k]),
            .grant_i (grant_c[k]),
            .seq_o   (seq_c[k+1]),
            .defer_o (defer_c[k+1]),
            .hit_o   (hit_c[k+1]),
            .grant_o (grant_c[k+1])
        );
    end

    assign seq_o   = seq_c[STAGES];
    assign defer_o = defer_c[STAGES];
    assign hit_o   = hit_c[STAGES];
    assign grant_o = grant_c[STAGES];
endmodule

// File: rtl/rr_retire.sv
module rr_retire #(
    parameter int unsigned UNITS = 4
) (
    input  logic [UNITS-1:0] busy_i,
    input  logic [UNITS-1:0] seq_i,
    input  logic [UNITS-1:0] defer_i,
    output logic [UNITS-1:0] seq_o,
    output logic [UNITS-1:0] defer_o
);
    localparam logic [UNITS-1:0] GROUP = {UNITS{1'b1}};

    function automatic logic [UNITS-1:0] top_bit(input logic [UNITS-1:0] m);
        logic [UNITS-1:0] r;
        r = '0;
        for (int i = 0; i < UNITS; i++) begin
            if (m[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

    logic [UNITS-1:0] seq_w;
    logic [UNITS-1:0] defer_w;
    logic [UNITS-1:0] id_w;
    logic [UNITS-1:0] cand_w;

    // Units leave one at a time, highest index first.
    always_comb begin
        seq_w   = seq_i;
        defer_w = defer_i;
        id_w    = '0;
        cand_w  = '0;
        for (int i = UNITS - 1; i >= 0; i--) begin
            if (busy_i[i]) begin
                id_w    = '0;
                id_w[i] = 1'b1;
                cand_w  = top_bit(seq_w);
                if (id_w > cand_w) begin
                    defer_w = defer_w | id_w;
                end
                seq_w = seq_w & ~id_w;
                if (seq_w == '0) begin
                    seq_w   = GROUP ^ defer_w;
                    defer_w = '0;
                end
            end
        end
        seq_o   = seq_w;
        defer_o = defer_w;
    end
endmodule

// File: rtl/rr_unit_select.sv
module rr_unit_select
    import rr_unit_select_pkg::*;
#(
    parameter int unsigned UNITS = RUS_UNITS_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pick_req,
    output logic [UNITS-1:0] grant_onehot,
    output logic             grant_hit,
    input  logic [UNITS-1:0] busy_vec,
    input  logic [UNITS-1:0] free_vec,
    output logic             any_free
);
    localparam logic [UNITS-1:0] GROUP = {UNITS{1'b1}};

    typedef struct packed {
        logic [UNITS-1:0] ready;
        logic [UNITS-1:0] seq;
        logic [UNITS-1:0] defer;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [UNITS-1:0] pk_seq, pk_defer, pk_grant;
    logic             pk_hit;
    logic [UNITS-1:0] mid_seq, mid_defer;
    logic [UNITS-1:0] rt_seq, rt_defer;

    rr_pick #(.UNITS(UNITS)) u_pick (
        .ready_i (st_q.ready),
        .seq_i   (st_q.seq),
        .defer_i (st_q.defer),
        .seq_o   (pk_seq),
        .defer_o (pk_defer),
        .hit_o   (pk_hit),
        .grant_o (pk_grant)
    );

    rr_retire #(.UNITS(UNITS)) u_retire (
        .busy_i  (busy_vec),
        .seq_i   (mid_seq),
        .defer_i (mid_defer),
        .seq_o   (rt_seq),
        .defer_o (rt_defer)
    );

    always_comb begin
        mid_seq      = (pick_req && pk_hit) ? pk_seq   : st_q.seq;
        mid_defer    = (pick_req && pk_hit) ? pk_defer : st_q.defer;
        grant_onehot = pick_req ? pk_grant : '0;
        grant_hit    = pick_req && pk_hit;
        any_free     = st_q.ready != '0;
        st_d.ready   = (st_q.ready & ~busy_vec) | free_vec;
        st_d.seq     = rt_seq;
        st_d.defer   = rt_defer;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ready <= GROUP;
            st_q.seq   <= GROUP;
            st_q.defer <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_onehot) && (pick_req || grant_onehot == '0));
    assert_hit_when_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_req && st_q.ready != '0) |-> (grant_hit && grant_onehot != '0));
    assert_grant_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_onehot & ~st_q.ready) == '0);
    assert_seq_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seq != '0);
    assert_defer_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seq & st_q.defer) == '0);
    assert_busy_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_vec != '0) |=> ((st_q.ready & $past(busy_vec & ~free_vec)) == '0));
    assert_free_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (free_vec != '0) |=> ((st_q.ready & $past(free_vec)) == $past(free_vec)));
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pick_req && busy_vec == '0) |=> ($stable(st_q.seq) && $stable(st_q.defer)));
endmodule

// File: tb/rr_unit_select_bench.sv
module rr_unit_select_bench;
    localparam int N = 4;
    localparam logic [N-1:0] ALL = {N{1'b1}};

    typedef struct {
        logic [N-1:0] grant;
        logic         hit;
        logic         free;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pick_req = 1'b0;
    logic [N-1:0] busy_vec = '0;
    logic [N-1:0] free_vec = '0;
    logic [N-1:0] grant_onehot;
    logic grant_hit, any_free;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    exp_t sb[$];

    logic [N-1:0] m_ready, m_seq, m_defer;

    always #10 clk = ~clk;

    rr_unit_select #(.UNITS(N)) u_rr_unit_select (
        .clk(clk), .rst_n(rst_n), .pick_req(pick_req),
        .grant_onehot(grant_onehot), .grant_hit(grant_hit),
        .busy_vec(busy_vec), .free_vec(free_vec), .any_free(any_free)
    );

    function automatic logic [N-1:0] hi(input logic [N-1:0] m);
        for (int i = N - 1; i >= 0; i--) if (m[i]) return ALL & (1 << i);
        return '0;
    endfunction

    task automatic step(input logic req, input logic [N-1:0] busy,
                        input logic [N-1:0] rel, input string tag);
        exp_t e;
        logic [N-1:0] s, d, c, g, id;
        logic found;
        @(negedge clk);
        pick_req = req; busy_vec = busy; free_vec = rel;
        // R3: walk candidates from the top, refilling per R4
        s = m_seq; d = m_defer; g = '0; found = 0;
        for (int k = 0; k < 3 * N && !found; k++) begin
            c = hi(s);
            if ((c & m_ready) != '0) begin g = c; found = 1; end
            else begin
                s = s & ~c;
                if (s == '0) begin s = ALL ^ d; d = '0; end
            end
        end
        e.grant = req ? g : '0;
        e.hit = req && found;
        e.free = m_ready != '0;
        e.tag = tag;
        sb.push_back(e);
        // R9: skips commit only on a granted request
        if (!(req && found)) begin s = m_seq; d = m_defer; end
        // R5/R6: removals from the top index down
        for (int i = N - 1; i >= 0; i--) begin
            if (busy[i]) begin
                id = ALL & (1 << i);
                if (id > hi(s)) d = d | id;
                s = s & ~id;
                if (s == '0) begin s = ALL ^ d; d = '0; end
            end
        end
        m_seq = s; m_defer = d;
        m_ready = (m_ready & ~busy) | rel;   // R7
    endtask

    task automatic check(input string what, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check({e.tag, " R2/R3 grant"}, grant_onehot, e.grant);
                check({e.tag, " R2 hit"}, {{(N-1){1'b0}}, grant_hit}, {{(N-1){1'b0}}, e.hit});
                check({e.tag, " R8 any_free"}, {{(N-1){1'b0}}, any_free}, {{(N-1){1'b0}}, e.free});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(20 * 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin : driver
        m_ready = ALL; m_seq = ALL; m_defer = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: first request gets the top unit
        step(1, '0, '0, "R1 reset");
        // R5: occupy granted units in turn
        step(1, 4'b1000, '0, "R5 take3");
        step(1, 4'b0100, '0, "R5 take2");
        step(1, 4'b0010, '0, "R5 take1");
        step(1, 4'b0001, '0, "R5 take0");
        // R2: none free, request gets nothing
        step(1, '0, '0, "R2 nofree");
        // R7: free all, release wins over busy
        step(0, 4'b0001, 4'b1111, "R7 relwin");
        step(1, '0, '0, "R7 after");
        // R4: defer a unit above the candidate, then drain to a refill
        step(1, 4'b1000, '0, "R4 a");
        step(0, '0, 4'b1000, "R4 b");
        step(0, 4'b1000, '0, "R4 c");
        step(0, '0, 4'b1000, "R4 d");
        step(1, 4'b0100, 4'b0100, "R4 e");
        step(1, 4'b0010, 4'b0010, "R4 f");
        step(1, 4'b0001, 4'b0001, "R4 g");
        step(1, '0, '0, "R4 refill");
        // R6: two units leave in one cycle
        step(0, 4'b0110, '0, "R6 multi");
        step(1, '0, '0, "R6 after");
        // R3/R9: skip a non-ready candidate, idle holds state
        step(0, '0, 4'b1111, "R3 prep");
        step(0, 4'b1000, '0, "R3 busy");
        step(0, '0, '0, "R9 idle");
        step(1, '0, '0, "R3 skip");
        step(0, '0, 4'b1000, "R9 rel");
        step(1, '0, '0, "R9 committed");
        // mixed random traffic
        for (int n = 0; n < 300; n++) begin
            logic [N-1:0] b, r;
            b = (($urandom % 3) == 0) ? N'($urandom) : (ALL & (1 << ($urandom % N)));
            r = (($urandom % 2) == 0) ? N'($urandom) : '0;
            step(1'($urandom), b, r, "rand");
        end
        step(0, '0, '0, "drain");
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule